// File: doc/BRIEF.md
# Virtual Address Region Attribute Decoder

This block sits between an address generator and the memory system. Each cycle it takes one virtual address and finds which fixed region of the 4 GB space the address falls in. That region decides four things: whether the address is translated, how the physical address is formed, whether the access may be cached, and which control bit chooses between write-through and copy-back. It also decides whether the access goes to the on-chip I/O space.

Two regions are translated. For those, the block issues a lookup on an external translation port, which answers in the same cycle with a hit flag, a page number, a page-size flag and a per-page cache bit. The other regions get their physical address by clearing the three top address bits, except the I/O region, which passes through unchanged. User-mode accesses above the lower half are rejected. A translated page that has its cache bit set but lands in the on-chip control window is demoted to uncacheable and flagged. All results appear on one registered output stage.

Top module: `vaddr_region_decode`

## Requirements
- R1: Regions are chosen by virtual address bits [31:29]. The values 000 to 011 select the user/translated low region (0x00000000–0x7FFFFFFF). 100 selects the cached direct region, 101 the uncached direct region, 110 the translated high region and 111 the I/O region.
- R2: In the low or high translated region with `mmu_en`=0, `tlb_req` stays 0. The physical address is the virtual address with bits [31:29] cleared, and `out_cacheable` equals `cache_en`.
- R3: In the low or high translated region with `mmu_en`=1, `tlb_req` is 1 in the request cycle and `tlb_vaddr` carries the address. On a hit with `tlb_size4k`=0 the physical address is {`tlb_ppn`, va[9:0]}. With `tlb_size4k`=1 it is {`tlb_ppn`[21:2], va[11:0]}.
- R4: For a translated hit, `out_cacheable` = `cache_en` AND `tlb_cbit`. For the low and high regions, `out_wthrough` equals `wt_sel` when the access is cacheable and is 0 otherwise.
- R5: In the cached direct region, `tlb_req` is always 0 and the physical address is va with bits [31:29] cleared. `out_cacheable` equals `cache_en`. `out_wthrough` = NOT `cb_sel` when cacheable and 0 otherwise, and `wt_sel` has no effect.
- R6: In the uncached direct region, `tlb_req` is 0, the physical address is va with bits [31:29] cleared, and `out_cacheable` is 0 whatever `cache_en` is.
- R7: In the I/O region, `out_io_sel` is 1, the physical address equals the virtual address, and `out_cacheable` and `tlb_req` are 0.
- R8: With `user_mode`=1 and va[31]=1, `out_addr_err` is 1, `out_valid` is 0 and `tlb_req` is 0, even when the translation port would hit.
- R9: A translated lookup with `tlb_hit`=0 gives `out_tlb_miss`=1 and `out_valid`=0. In that case the physical address output is 0.
- R10: On a translated hit with `tlb_cbit`=1 whose physical bits [28:26] equal 001, `out_cfg_viol` is 1, `out_cacheable` is 0 and `out_valid` stays 1. This holds independent of `cache_en`.
- R11: Outputs are registered. They show the request presented in the previous cycle. A cycle with `req_valid`=0 gives all output flags 0 in the following cycle, and reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| user_mode | input | 1 | 1 = user privilege |
| mmu_en | input | 1 | Translation enable |
| cache_en | input | 1 | Global cache enable |
| wt_sel | input | 1 | Write-through select for translated regions |
| cb_sel | input | 1 | Copy-back select for cached direct region |
| tlb_req | output | 1 | Lookup request to translation port |
| tlb_vaddr | output | 32 | Address presented for lookup |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 22 | Physical page number in 1 KB units |
| tlb_size4k | input | 1 | 1 = 4 KB page, 0 = 1 KB page |
| tlb_cbit | input | 1 | Per-page cacheable bit |
| out_valid | output | 1 | Registered result valid |
| out_paddr | output | 32 | Physical address |
| out_cacheable | output | 1 | Access may be cached |
| out_wthrough | output | 1 | 1 = write-through, 0 = copy-back |
| out_io_sel | output | 1 | On-chip I/O space selected |
| out_addr_err | output | 1 | Privilege address error |
| out_tlb_miss | output | 1 | Translation miss |
| out_cfg_viol | output | 1 | Cached page mapped onto control window |

## Verification
Several decisions can meet in a single cycle. The bench sets up those meetings on purpose. A user-mode access to the translated high region with the MMU on and a hitting translation port asks for both the privilege error and a lookup. Here the error must win, with `tlb_req` low in that cycle and no valid result one cycle later. A hit on a cache-bit page inside the control window asks for both a cacheable result and the window demotion. The check expects the violation flag with a valid, uncacheable result, once with the global cache enable on and once with it off.

// File: rtl/vrad_pkg.sv
package vrad_pkg;
  typedef enum logic [2:0] {
    AREA_LOW  = 3'd0,
    AREA_CDIR = 3'd1,
    AREA_UDIR = 3'd2,
    AREA_HIGH = 3'd3,
    AREA_IO   = 3'd4
  } area_e;

  typedef struct packed {
    logic valid;
    logic cacheable;
    logic wthrough;
    logic io_sel;
    logic addr_err;
    logic tlb_miss;
    logic cfg_viol;
  } attr_t;
endpackage

// File: rtl/vrad_area_classify.sv
module vrad_area_classify
  import vrad_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            user_mode,
  output area_e           area,
  output logic            priv_err
);
  localparam int TOP = VA_W - 1;

  logic [2:0] sel;
  assign sel = vaddr[TOP -: 3];

  // R1: region select from the three top address bits
  always_comb begin
    unique casez (sel)
      3'b0??:  area = AREA_LOW;
      3'b100:  area = AREA_CDIR;
      3'b101:  area = AREA_UDIR;
      3'b110:  area = AREA_HIGH;
      default: area = AREA_IO;
    endcase
  end

  // R8: user mode may only touch the lower half
  assign priv_err = user_mode & vaddr[TOP];
endmodule

// File: rtl/vrad_xlate.sv
module vrad_xlate
  import vrad_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFS_SMALL = 10,
  parameter int OFS_LARGE = 12,
  parameter int CTRL_AREA = 1
) (
  input  logic                      req_valid,
  input  area_e                     area,
  input  logic                      priv_err,
  input  logic                      mmu_en,
  input  logic                      cache_en,
  input  logic                      wt_sel,
  input  logic                      cb_sel,
  input  logic [VA_W-1:0]           vaddr,
  input  logic                      tlb_hit,
  input  logic [VA_W-OFS_SMALL-1:0] tlb_ppn,
  input  logic                      tlb_size4k,
  input  logic                      tlb_cbit,
  output logic                      tlb_req,
  output logic [VA_W-1:0]           paddr,
  output attr_t                     attr
);
  localparam int PPN_W    = VA_W - OFS_SMALL;
  localparam int DROP     = OFS_LARGE - OFS_SMALL;
  localparam int PAREA_LSB = VA_W - 6;

  logic [VA_W-1:0] seg_clear;
  logic [VA_W-1:0] page_pa;
  logic            translated;
  logic            in_ctrl;

  assign seg_clear  = {3'b000, vaddr[VA_W-4:0]};
  assign translated = ((area == AREA_LOW) || (area == AREA_HIGH)) && mmu_en;
  assign tlb_req    = req_valid && !priv_err && translated;

  // R3: page size picks how many offset bits come from the virtual address
  assign page_pa = tlb_size4k ? {tlb_ppn[PPN_W-1:DROP], vaddr[OFS_LARGE-1:0]}
                              : {tlb_ppn, vaddr[OFS_SMALL-1:0]};
  assign in_ctrl = (page_pa[PAREA_LSB+2:PAREA_LSB] == 3'(CTRL_AREA));

  always_comb begin
    attr  = '0;
    paddr = '0;
    if (req_valid) begin
      if (priv_err) begin
        attr.addr_err = 1'b1;
      end else begin
        unique case (area)
          AREA_LOW, AREA_HIGH: begin
            if (mmu_en) begin
              if (!tlb_hit) begin
                attr.tlb_miss = 1'b1;
              end else begin
                attr.valid = 1'b1;
                paddr      = page_pa;
                if (tlb_cbit && in_ctrl) attr.cfg_viol  = 1'b1;
                else                     attr.cacheable = cache_en & tlb_cbit;
              end
            end else begin
              attr.valid     = 1'b1;
              paddr          = seg_clear;
              attr.cacheable = cache_en;
            end
            attr.wthrough = attr.cacheable & wt_sel;
          end
          AREA_CDIR: begin
            attr.valid     = 1'b1;
            paddr          = seg_clear;
            attr.cacheable = cache_en;
            attr.wthrough  = cache_en & ~cb_sel;
          end
          AREA_UDIR: begin
            attr.valid = 1'b1;
            paddr      = seg_clear;
          end
          default: begin
            attr.valid  = 1'b1;
            attr.io_sel = 1'b1;
            paddr       = vaddr;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vaddr_region_decode.sv
module vaddr_region_decode
  import vrad_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFS_SMALL = 10,
  parameter int OFS_LARGE = 12,
  parameter int CTRL_AREA = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic                      user_mode,
  input  logic                      mmu_en,
  input  logic                      cache_en,
  input  logic                      wt_sel,
  input  logic                      cb_sel,
  output logic                      tlb_req,
  output logic [VA_W-1:0]           tlb_vaddr,
  input  logic                      tlb_hit,
  input  logic [VA_W-OFS_SMALL-1:0] tlb_ppn,
  input  logic                      tlb_size4k,
  input  logic                      tlb_cbit,
  output logic                      out_valid,
  output logic [VA_W-1:0]           out_paddr,
  output logic                      out_cacheable,
  output logic                      out_wthrough,
  output logic                      out_io_sel,
  output logic                      out_addr_err,
  output logic                      out_tlb_miss,
  output logic                      out_cfg_viol
);
  area_e           area;
  logic            priv_err;
  logic [VA_W-1:0] paddr_d;
  attr_t           attr_d;
  attr_t           attr_q;

  vrad_area_classify #(.VA_W(VA_W)) u_cls (
    .vaddr     (req_vaddr),
    .user_mode (user_mode),
    .area      (area),
    .priv_err  (priv_err)
  );

  vrad_xlate #(
    .VA_W(VA_W), .OFS_SMALL(OFS_SMALL), .OFS_LARGE(OFS_LARGE), .CTRL_AREA(CTRL_AREA)
  ) u_xl (
    .req_valid  (req_valid),
    .area       (area),
    .priv_err   (priv_err),
    .mmu_en     (mmu_en),
    .cache_en   (cache_en),
    .wt_sel     (wt_sel),
    .cb_sel     (cb_sel),
    .vaddr      (req_vaddr),
    .tlb_hit    (tlb_hit),
    .tlb_ppn    (tlb_ppn),
    .tlb_size4k (tlb_size4k),
    .tlb_cbit   (tlb_cbit),
    .tlb_req    (tlb_req),
    .paddr      (paddr_d),
    .attr       (attr_d)
  );

  assign tlb_vaddr = req_vaddr;

  // R11: single registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q    <= '0;
      out_paddr <= '0;
    end else begin
      attr_q    <= attr_d;
      out_paddr <= paddr_d;
    end
  end

  assign out_valid     = attr_q.valid;
  assign out_cacheable = attr_q.cacheable;
  assign out_wthrough  = attr_q.wthrough;
  assign out_io_sel    = attr_q.io_sel;
  assign out_addr_err  = attr_q.addr_err;
  assign out_tlb_miss  = attr_q.tlb_miss;
  assign out_cfg_viol  = attr_q.cfg_viol;

  a_r8_no_lookup_on_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && user_mode && req_vaddr[VA_W-1]) |-> !tlb_req);

  a_r6_udir_no_lookup: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_vaddr[VA_W-1 -: 3] == 3'b101) |-> !tlb_req);

  a_r9_miss_invalid: assert property (@(posedge clk) disable iff (rst)
    out_tlb_miss |-> !out_valid);

  a_r7_io_uncached: assert property (@(posedge clk) disable iff (rst)
    out_io_sel |-> (out_valid && !out_cacheable));

  a_r10_viol_uncached: assert property (@(posedge clk) disable iff (rst)
    out_cfg_viol |-> (out_valid && !out_cacheable));

  a_r4_wt_needs_cache: assert property (@(posedge clk) disable iff (rst)
    out_wthrough |-> out_cacheable);

  a_r11_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_addr_err && !out_tlb_miss));
endmodule

// File: tb/vaddr_region_decode_tb.sv
module vaddr_region_decode_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, user_mode, mmu_en, cache_en, wt_sel, cb_sel;
  logic [31:0] req_vaddr;
  logic        tlb_req;
  logic [31:0] tlb_vaddr;
  logic        tlb_hit, tlb_size4k, tlb_cbit;
  logic [21:0] tlb_ppn;
  logic        out_valid, out_cacheable, out_wthrough, out_io_sel;
  logic        out_addr_err, out_tlb_miss, out_cfg_viol;
  logic [31:0] out_paddr;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  vaddr_region_decode u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .user_mode(user_mode), .mmu_en(mmu_en), .cache_en(cache_en),
    .wt_sel(wt_sel), .cb_sel(cb_sel), .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_size4k(tlb_size4k),
    .tlb_cbit(tlb_cbit), .out_valid(out_valid), .out_paddr(out_paddr),
    .out_cacheable(out_cacheable), .out_wthrough(out_wthrough),
    .out_io_sel(out_io_sel), .out_addr_err(out_addr_err),
    .out_tlb_miss(out_tlb_miss), .out_cfg_viol(out_cfg_viol)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // drive a request at a falling edge, check the lookup request before the
  // capturing edge, then check the registered outputs at the next falling edge
  task automatic run(input string req, input logic [31:0] va, input logic usr,
                     input logic mmu, input logic ce, input logic wt, input logic cb,
                     input logic hit, input logic [21:0] ppn, input logic s4k,
                     input logic cbit, input logic e_req,
                     input logic e_val, input logic [31:0] e_pa, input logic e_c,
                     input logic e_wt, input logic e_io, input logic e_err,
                     input logic e_miss, input logic e_viol);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; user_mode = usr; mmu_en = mmu;
    cache_en = ce; wt_sel = wt; cb_sel = cb; tlb_hit = hit; tlb_ppn = ppn;
    tlb_size4k = s4k; tlb_cbit = cbit;
    #1;
    chk(req, "tlb_req", 32'(tlb_req), 32'(e_req));
    if (e_req) chk(req, "tlb_vaddr", tlb_vaddr, va);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "valid", 32'(out_valid), 32'(e_val));
    if (e_val || e_miss) chk(req, "paddr", out_paddr, e_pa);
    chk(req, "cacheable", 32'(out_cacheable), 32'(e_c));
    chk(req, "wthrough", 32'(out_wthrough), 32'(e_wt));
    chk(req, "io_sel", 32'(out_io_sel), 32'(e_io));
    chk(req, "addr_err", 32'(out_addr_err), 32'(e_err));
    chk(req, "tlb_miss", 32'(out_tlb_miss), 32'(e_miss));
    chk(req, "cfg_viol", 32'(out_cfg_viol), 32'(e_viol));
  endtask

  task automatic t_reset();
    chk("R11", "reset valid", 32'(out_valid), 32'd0);
    chk("R11", "reset paddr", out_paddr, 32'd0);
    chk("R11", "reset flags", 32'({out_addr_err, out_tlb_miss, out_cfg_viol, out_io_sel}), 32'd0);
  endtask

  task automatic t_untranslated_low_high();
    run("R2", 32'h1234_5678, 0, 0, 1, 1, 0, 1, 22'h3FFFFF, 0, 0, 0,
        1, 32'h1234_5678, 1, 1, 0, 0, 0, 0);
    run("R2", 32'hC123_4560, 0, 0, 0, 1, 0, 1, 22'h0, 0, 1, 0,
        1, 32'h0123_4560, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_translated();
    // R3 1 KB page, R4 cacheable with copy-back
    run("R3", 32'h0040_1ABC, 0, 1, 1, 0, 1, 1, 22'h001234, 0, 1, 1,
        1, 32'h0048_D2BC, 1, 0, 0, 0, 0, 0);
    // R3 4 KB page in high region, page bit clear -> uncached (R4)
    run("R3", 32'hC000_0ABC, 0, 1, 1, 1, 0, 1, 22'h001235, 1, 0, 1,
        1, 32'h0048_DABC, 0, 0, 0, 0, 0, 0);
    // R4 global enable off
    run("R4", 32'h0000_2000, 0, 1, 0, 1, 0, 1, 22'h000100, 0, 1, 1,
        1, 32'h0004_0000, 0, 0, 0, 0, 0, 0);
    // R4 write-through selected
    run("R4", 32'h0000_2004, 0, 1, 1, 1, 0, 1, 22'h000100, 0, 1, 1,
        1, 32'h0004_0004, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_cached_direct();
    run("R5", 32'h8765_4321, 0, 1, 1, 1, 1, 1, 22'h0, 0, 0, 0,
        1, 32'h0765_4321, 1, 0, 0, 0, 0, 0);
    run("R5", 32'h8765_4321, 0, 1, 1, 0, 0, 1, 22'h0, 0, 0, 0,
        1, 32'h0765_4321, 1, 1, 0, 0, 0, 0);
    run("R5", 32'h9FFF_FFFF, 0, 0, 0, 1, 0, 0, 22'h0, 0, 0, 0,
        1, 32'h1FFF_FFFF, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_uncached_direct_io();
    run("R6", 32'hA000_1000, 0, 1, 1, 1, 0, 1, 22'h0, 0, 1, 0,
        1, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
    run("R7", 32'hFF00_0010, 0, 1, 1, 1, 1, 1, 22'h0, 0, 1, 0,
        1, 32'hFF00_0010, 0, 0, 1, 0, 0, 0);
    run("R1", 32'hE000_0000, 0, 0, 1, 0, 0, 0, 22'h0, 0, 0, 0,
        1, 32'hE000_0000, 0, 0, 1, 0, 0, 0);
    run("R1", 32'h7FFF_FFFC, 1, 0, 1, 0, 0, 0, 22'h0, 0, 0, 0,
        1, 32'h1FFF_FFFC, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_user_error();
    // error must win over a hitting lookup
    run("R8", 32'hC000_0000, 1, 1, 1, 0, 0, 1, 22'h001234, 0, 1, 0,
        0, 32'h0, 0, 0, 0, 1, 0, 0);
    run("R8", 32'h8000_0000, 1, 0, 1, 0, 0, 1, 22'h0, 0, 0, 0,
        0, 32'h0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_miss();
    run("R9", 32'h0000_0400, 0, 1, 1, 0, 0, 0, 22'h001234, 0, 1, 1,
        0, 32'h0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_ctrl_window();
    run("R10", 32'h0000_0123, 0, 1, 1, 0, 0, 1, 22'h010000, 0, 1, 1,
        1, 32'h0400_0123, 0, 0, 0, 0, 0, 1);
    run("R10", 32'h0000_0123, 0, 1, 0, 0, 0, 1, 22'h010000, 0, 1, 1,
        1, 32'h0400_0123, 0, 0, 0, 0, 0, 1);
    run("R10", 32'hC000_0FF0, 0, 1, 1, 0, 0, 1, 22'h010000, 1, 0, 1,
        1, 32'h0400_0FF0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'hC000_0000; user_mode = 1'b1;
    @(negedge clk);
    chk("R11", "idle valid", 32'(out_valid), 32'd0);
    chk("R11", "idle err", 32'(out_addr_err), 32'd0);
    chk("R11", "idle miss", 32'(out_tlb_miss), 32'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; user_mode = 1'b0;
    mmu_en = 1'b0; cache_en = 1'b0; wt_sel = 1'b0; cb_sel = 1'b0;
    tlb_hit = 1'b0; tlb_ppn = '0; tlb_size4k = 1'b0; tlb_cbit = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_untranslated_low_high();
    t_translated();
    t_cached_direct();
    t_uncached_direct_io();
    t_user_error();
    t_miss();
    t_ctrl_window();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule